// File: doc/BRIEF.md
# Address-Stretched CPU Clock Generator with Aligned Peripheral Clock

This block derives two bus clocks for a small 8-bit microprocessor system from one fast reference clock. The CPU clock has a programmable half-period. At the last reference cycle of every CPU low phase the block looks at the address bus. If a slow region is selected, it lengthens the following high phase by that region's programmed wait count, so the slow device has time to respond.

The second output is a free-running peripheral clock for a timer/I/O device. Its half-period comes from a separate divisor and is never disturbed by CPU stretching. When the CPU addresses that peripheral, the CPU clock holds low until the peripheral clock is about to rise. Both clocks then rise together, stay high together for one peripheral half-period and fall together. After that the CPU clock goes back to its own timing. During the high phase of the CPU clock, a one-hot chip select names the decoded region.

Top module: `rcg_clkgen`

## Requirements
- R1: While reset is asserted, the CPU clock, the peripheral clock and all chip selects are low.
- R2: Outside a peripheral access, every CPU low phase lasts exactly D reference cycles. D is the CPU divisor input taken at the falling edge of the CPU clock, and a value of 0 counts as 1.
- R3: The CPU high phase lasts D cycles for RAM, D plus the LCD wait for the LCD region and D plus the ROM wait for the ROM region. The wait inputs are taken at the last low cycle.
- R4: The address decode uses these regions and chip-select bits, in priority order: peripheral 0x6000–0x600F is bit 1; LCD 0x7000–0x7003 is bit 2; ROM 0x8000–0xFFFF is bit 3; every other address is RAM, bit 0. The decoded bit is high during the whole CPU high phase, and all bits are low during the low phase.
- R5: Every peripheral clock half-period equals the peripheral divisor (0 counts as 1) taken at the peripheral clock's rising edge. This holds during CPU stretches and alignment holds as well.
- R6: On a peripheral access, the CPU low phase lasts at least D cycles, and the CPU clock rises in the same reference cycle as the peripheral clock.
- R7: On a peripheral access, the CPU high phase equals one peripheral high half-period, and the CPU clock falls in the same cycle as the peripheral clock.
- R8: A divisor change made partway through a period does not alter that period. It takes effect at the next latching edge named in R2 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_i | input | 16 | CPU address bus |
| cpu_div_i | input | 4 | CPU clock half-period in reference cycles |
| per_div_i | input | 4 | Peripheral clock half-period in reference cycles |
| lcd_wait_i | input | 4 | Extra high cycles for the LCD region |
| rom_wait_i | input | 4 | Extra high cycles for the ROM region |
| cpu_clk_o | output | 1 | Variable CPU clock |
| per_clk_o | output | 1 | Steady peripheral clock |
| cs_o | output | 4 | One-hot region select, valid while CPU clock is high |

## Verification
The hardest situation to reach is a divisor change that lands in the middle of an alignment hold or a stretched high phase. That is where the two clocks' latching points interact. The stimulus changes both divisors at random reference cycles throughout the run. It also selects the peripheral region often, so peripheral accesses overlap those changes. A directed opening sequence hits each region's boundary addresses.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
    localparam int unsigned NUM_REG = 4;

    // encoding equals chip-select bit index
    typedef enum logic [1:0] {
        REG_RAM = 2'd0,
        REG_PER = 2'd1,
        REG_LCD = 2'd2,
        REG_ROM = 2'd3
    } region_e;
endpackage

// File: rtl/rcg_decode.sv
module rcg_decode
    import rcg_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned WAIT_W = 4,
    parameter logic [ADDR_W-1:0] PER_LO = 16'h6000,
    parameter logic [ADDR_W-1:0] PER_HI = 16'h600F,
    parameter logic [ADDR_W-1:0] LCD_LO = 16'h7000,
    parameter logic [ADDR_W-1:0] LCD_HI = 16'h7003,
    parameter logic [ADDR_W-1:0] ROM_LO = 16'h8000,
    parameter logic [ADDR_W-1:0] ROM_HI = 16'hFFFF
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WAIT_W-1:0] lcd_wait_i,
    input  logic [WAIT_W-1:0] rom_wait_i,
    output region_e           region_o,
    output logic [WAIT_W-1:0] wait_o
);
    always_comb begin
        if (addr_i >= PER_LO && addr_i <= PER_HI) begin
            region_o = REG_PER;
            wait_o   = '0;
        end else if (addr_i >= LCD_LO && addr_i <= LCD_HI) begin
            region_o = REG_LCD;
            wait_o   = lcd_wait_i;
        end else if (addr_i >= ROM_LO && addr_i <= ROM_HI) begin
            region_o = REG_ROM;
            wait_o   = rom_wait_i;
        end else begin
            region_o = REG_RAM;
            wait_o   = '0;
        end
    end
endmodule

// File: rtl/rcg_per_div.sv
module rcg_per_div #(
    parameter int unsigned DIV_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             per_clk_o,
    output logic             rise_next_o,
    output logic             fall_next_o
);
    typedef struct packed {
        logic             lvl;
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] div;
    } per_st_t;

    per_st_t st_d, st_q;
    logic    half_end;
    logic [DIV_W-1:0] div_fix;

    always_comb begin
        div_fix     = (div_i == '0) ? DIV_W'(1) : div_i;
        half_end    = (st_q.cnt == st_q.div - DIV_W'(1));
        rise_next_o = !st_q.lvl && half_end;
        fall_next_o = st_q.lvl && half_end;
        st_d        = st_q;
        if (half_end) begin
            st_d.lvl = !st_q.lvl;
            st_d.cnt = '0;
            if (!st_q.lvl) st_d.div = div_fix;  // latch at rising edge
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
        if (rst_i) begin
            st_d.lvl = 1'b0;
            st_d.cnt = '0;
            st_d.div = div_fix;
        end
    end

    always_ff @(posedge clk_i) st_q <= st_d;

    assign per_clk_o = st_q.lvl;

    AST_PER_CNT_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.div != '0) && (st_q.cnt < st_q.div)); // R5
    AST_PER_DIV_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!rst_i) && !$rose(st_q.lvl)) |-> $stable(st_q.div)); // R8
endmodule

// File: rtl/rcg_cpu_seq.sv
module rcg_cpu_seq
    import rcg_pkg::*;
#(
    parameter int unsigned DIV_W  = 4,
    parameter int unsigned WAIT_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [DIV_W-1:0]  cpu_div_i,
    input  region_e           region_i,
    input  logic [WAIT_W-1:0] wait_i,
    input  logic              per_rise_next_i,
    input  logic              per_fall_next_i,
    output logic              cpu_clk_o,
    output region_e           region_o
);
    localparam int unsigned CNT_W = ((DIV_W > WAIT_W) ? DIV_W : WAIT_W) + 1;

    typedef enum logic [1:0] {ST_LOW, ST_HOLD, ST_HIGH} cpu_state_e;

    typedef struct packed {
        cpu_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] hi_len;
        region_e          region;
    } cpu_st_t;

    cpu_st_t st_d, st_q;
    logic [DIV_W-1:0] div_fix;
    logic             low_end;
    logic             high_end;

    always_comb begin
        div_fix  = (cpu_div_i == '0) ? DIV_W'(1) : cpu_div_i;
        low_end  = (st_q.cnt == CNT_W'(st_q.div) - CNT_W'(1));
        high_end = (st_q.region == REG_PER) ? per_fall_next_i
                                            : (st_q.cnt == st_q.hi_len - CNT_W'(1));
        st_d = st_q;
        unique case (st_q.state)
            ST_LOW: begin
                if (low_end) begin
                    st_d.region = region_i;  // decode on stable address
                    st_d.cnt    = '0;
                    st_d.hi_len = CNT_W'(st_q.div) + CNT_W'(wait_i);
                    if (region_i == REG_PER && !per_rise_next_i) st_d.state = ST_HOLD;
                    else                                           st_d.state = ST_HIGH;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            ST_HOLD: begin
                if (per_rise_next_i) st_d.state = ST_HIGH;
            end
            default: begin
                if (high_end) begin
                    st_d.state = ST_LOW;
                    st_d.cnt   = '0;
                    st_d.div   = div_fix;  // period boundary
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
        endcase
        if (rst_i) begin
            st_d.state  = ST_LOW;
            st_d.cnt    = '0;
            st_d.div    = div_fix;
            st_d.hi_len = '0;
            st_d.region = REG_RAM;
        end
    end

    always_ff @(posedge clk_i) st_q <= st_d;

    assign cpu_clk_o = (st_q.state == ST_HIGH);
    assign region_o  = st_q.region;

    AST_CPU_DIV_NONZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.div != '0); // R2
    AST_HOLD_ONLY_PER: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.state == ST_HOLD) |-> (st_q.region == REG_PER)); // R6
endmodule

// File: rtl/rcg_clkgen.sv
module rcg_clkgen
    import rcg_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DIV_W  = 4,
    parameter int unsigned WAIT_W = 4
) (
    input  logic                 clk_ref_i,
    input  logic                 rst_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DIV_W-1:0]     cpu_div_i,
    input  logic [DIV_W-1:0]     per_div_i,
    input  logic [WAIT_W-1:0]    lcd_wait_i,
    input  logic [WAIT_W-1:0]    rom_wait_i,
    output logic                 cpu_clk_o,
    output logic                 per_clk_o,
    output logic [NUM_REG-1:0]   cs_o
);
    region_e           dec_region;
    region_e           cur_region;
    logic [WAIT_W-1:0] dec_wait;
    logic              per_rise_next;
    logic              per_fall_next;

    rcg_decode #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_decode (
        .addr_i     (addr_i),
        .lcd_wait_i (lcd_wait_i),
        .rom_wait_i (rom_wait_i),
        .region_o   (dec_region),
        .wait_o     (dec_wait)
    );

    rcg_per_div #(.DIV_W(DIV_W)) u_per_div (
        .clk_i       (clk_ref_i),
        .rst_i       (rst_i),
        .div_i       (per_div_i),
        .per_clk_o   (per_clk_o),
        .rise_next_o (per_rise_next),
        .fall_next_o (per_fall_next)
    );

    rcg_cpu_seq #(.DIV_W(DIV_W), .WAIT_W(WAIT_W)) u_cpu_seq (
        .clk_i           (clk_ref_i),
        .rst_i           (rst_i),
        .cpu_div_i       (cpu_div_i),
        .region_i        (dec_region),
        .wait_i          (dec_wait),
        .per_rise_next_i (per_rise_next),
        .per_fall_next_i (per_fall_next),
        .cpu_clk_o       (cpu_clk_o),
        .region_o        (cur_region)
    );

    assign cs_o = cpu_clk_o ? (NUM_REG'(1) << cur_region) : '0;

    AST_CS_ONEHOT: assert property (@(posedge clk_ref_i) disable iff (rst_i)
        $onehot0(cs_o) && ((cs_o != '0) == cpu_clk_o)); // R4
    AST_CS_STEADY: assert property (@(posedge clk_ref_i) disable iff (rst_i)
        (cpu_clk_o && $past(cpu_clk_o)) |-> $stable(cs_o)); // R4
    AST_ALIGN_RISE: assert property (@(posedge clk_ref_i) disable iff (rst_i)
        ($rose(cpu_clk_o) && cs_o[REG_PER]) |-> $rose(per_clk_o)); // R6
    AST_ALIGN_FALL: assert property (@(posedge clk_ref_i) disable iff (rst_i)
        ($fell(cpu_clk_o) && $past(cs_o[REG_PER])) |-> $fell(per_clk_o)); // R7
endmodule

// File: tb/rcg_clkgen_bench.sv
module rcg_clkgen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = 16'h0100;
    logic [3:0]  cpu_div = 4'd1;
    logic [3:0]  per_div = 4'd3;
    logic [3:0]  lcd_wait = 4'd2;
    logic [3:0]  rom_wait = 4'd4;
    logic        cpu_clk, per_clk;
    logic [3:0]  cs;

    int pass_cnt = 0;
    int fail_cnt = 0;

    always #4 clk = ~clk;  // 125 MHz

    rcg_clkgen u_rcg_clkgen (
        .clk_ref_i (clk), .rst_i (rst), .addr_i (addr),
        .cpu_div_i (cpu_div), .per_div_i (per_div),
        .lcd_wait_i (lcd_wait), .rom_wait_i (rom_wait),
        .cpu_clk_o (cpu_clk), .per_clk_o (per_clk), .cs_o (cs)
    );

    // region codes: 0 RAM, 1 PER, 2 LCD, 3 ROM (R4)
    function automatic int exp_region(input logic [15:0] a);
        if (a >= 16'h6000 && a <= 16'h600F) return 1;
        if (a >= 16'h7000 && a <= 16'h7003) return 2;
        if (a >= 16'h8000) return 3;
        return 0;
    endfunction

    function automatic int fixdiv(input logic [3:0] d);
        return (d == 4'd0) ? 1 : int'(d);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        if (ok) pass_cnt++;
        else begin
            fail_cnt++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [15:0] pick_addr(input int kind);
        case (kind)
            0: return 16'h6000 + 16'($urandom % 16);
            1: return 16'h7000 + 16'($urandom % 4);
            2: return 16'h8000 + 16'($urandom % 32768);
            default: return 16'($urandom % 24576);
        endcase
    endfunction

    logic [15:0] directed [9] = '{16'h8000, 16'h6000, 16'h600F, 16'h6010,
                                  16'h7003, 16'h7004, 16'hFFFF, 16'h5FFF, 16'h6008};

    initial begin
        int unsigned seed_v;
        int cpu_run, per_run, cdiv_lat, per_lat, cur_reg, exp_hi, bus_idx;
        bit cpu_prev, per_prev, hung;
        seed_v = $urandom(32'd20240);
        hung = 1'b0;
        bus_idx = 0;
        cur_reg = 0;
        exp_hi = 0;
        repeat (5) begin
            @(negedge clk);
            check(!cpu_clk && !per_clk && cs == 4'd0, "R1", int'({cpu_clk, per_clk, cs}), 0);
        end
        rst = 1'b0;  // first free edge follows this negedge
        cpu_prev = 1'b0; per_prev = 1'b0;
        cpu_run = 1; per_run = 1;
        cdiv_lat = fixdiv(cpu_div);
        per_lat  = fixdiv(per_div);
        for (int cyc = 0; cyc < 30000; cyc++) begin
            @(negedge clk);
            // peripheral clock: steady halves (R5, R8)
            if (per_clk != per_prev) begin
                check(per_run == per_lat, "R5 R8", per_run, per_lat);
                if (per_clk) per_lat = fixdiv(per_div);
                per_run = 1;
            end else per_run++;
            // CPU clock
            if (cpu_clk && !cpu_prev) begin
                int er;
                er = exp_region(addr);
                check(cs == 4'(1 << er), "R4", int'(cs), 1 << er);
                if (er == 1)
                    check(cpu_run >= cdiv_lat && per_clk && !per_prev, "R6",
                          cpu_run, cdiv_lat);
                else
                    check(cpu_run == cdiv_lat, "R2 R8", cpu_run, cdiv_lat);
                exp_hi = cdiv_lat + ((er == 2) ? int'(lcd_wait) :
                                     (er == 3) ? int'(rom_wait) : 0);
                cur_reg = er;
                cpu_run = 1;
                // next bus cycle
                if (bus_idx < 9) addr = directed[bus_idx];
                else addr = pick_addr($urandom % 5);
                bus_idx++;
                lcd_wait = 4'($urandom % 8);
                rom_wait = 4'($urandom % 8);
            end else if (!cpu_clk && cpu_prev) begin
                if (cur_reg == 1)
                    check(cpu_run == per_lat && !per_clk && per_prev, "R7", cpu_run, per_lat);
                else
                    check(cpu_run == exp_hi, "R3", cpu_run, exp_hi);
                check(cs == 4'd0, "R4", int'(cs), 0);
                cdiv_lat = fixdiv(cpu_div);
                cpu_run = 1;
            end else cpu_run++;
            cpu_prev = cpu_clk;
            per_prev = per_clk;
            if (cpu_run > 500) begin
                hung = 1'b1;
                break;
            end
            if ($urandom % 64 == 0) cpu_div = 4'($urandom % 4);
            if ($urandom % 64 == 0) per_div = 4'($urandom % 6);
        end
        if (hung) check(1'b0, "watchdog", cpu_run, 500);
        $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
        $finish;
    end
endmodule